// File: doc/BRIEF.md
# Correctable Error Record Status Register

This block is a 32-bit status word, mapped into a register space, that keeps a record of correctable hardware errors found by nearby logic. Each error report arrives as a one-cycle strobe with an 8-bit error code. The register holds four things: a record-valid flag, a two-bit corrected-error field, an overflow flag that marks a second error arriving before the first was acknowledged, and the code of the earliest error that has not been acknowledged.

Software reads the word and acknowledges errors by writing ones to clear through a one-access-per-cycle register port. Each access carries a secure/non-secure attribute. The clear rules have guards so that software cannot lose an error. A flag can only be cleared when the flag that depends on it is cleared in the same write. A new error report always wins over a clear in the same cycle. A control input decides whether non-secure software may see the register at all.

Top module: `errrec_status`

## Requirements
- R1: After synchronous reset the register reads 0x00000000. The reserved bits 31, 29:28, 26 and 23:8 always read 0, and writing ones to them changes nothing.
- R2: The valid flag is bit 30. It becomes 1 in the cycle after any error report. Writing 1 to bit 30 clears it.
- R3: The overflow flag is bit 27. It becomes 1 when an error is reported while the corrected-error field is nonzero. Writing 1 to bit 27 clears it, and writing 0 leaves it unchanged.
- R4: The corrected-error field is bits 25:24. It becomes 0b10 on each error report and never holds another nonzero value. Only a write of 0b11 to it clears it; any other value written there is ignored.
- R5: A write of 0b11 to bits 25:24 is ignored while overflow is 1, unless the same write also has bit 27 set.
- R6: A write of 1 to bit 30 is ignored while the corrected-error field is nonzero, unless the same write also clears that field under R4 and R5.
- R7: Bits 7:0 hold the code of the earliest unacknowledged error. The code is captured when an error arrives while valid is 0, or when it arrives in the same cycle as an accepted valid clear. It is otherwise frozen while valid is 1. It reads 0 once valid is cleared. Writes to bits 7:0 are ignored.
- R8: While the non-secure-allow input is 0, a non-secure access reads as 0 and its write is ignored. Secure accesses are never blocked, and non-secure accesses behave like secure ones while the input is 1.
- R9: When an error report and a clear write land in the same cycle, the error wins. Valid and the corrected-error field end up set, and overflow is set if the field was nonzero before the cycle.
- R10: Read data is combinational and reflects the current register value while the select input is high. It is 0 otherwise. A write with the select input low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_valid_i | input | 1 | One-cycle strobe reporting a corrected error |
| err_code_i | input | 8 | Code of the reported error |
| ns_allow_i | input | 1 | 1 lets non-secure accesses reach the register |
| reg_sel_i | input | 1 | Address match for this register |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_ns_i | input | 1 | Access attribute, 1 = non-secure |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data |

## Verification
On every cycle, the assertions check the following. Reserved bits always read zero. Blocked non-secure reads return zero. Every error report sets valid and the corrected-error field in the next cycle, and sets overflow when the field was already nonzero. The field only ever holds 0b00 or 0b10. The code stays frozen while valid is held, and reads zero while valid is clear. The guarded clears (R5, R6) are also checked per cycle as properties that a blocked clear leaves the flag unchanged.

Some behaviour only the bench's directed scenarios can show. These are the exact values read back after specific write patterns, and the ignored write of 0b01 to the field. They also include the earliest-code rule across several reports, the race where a report and a full clear land in the same cycle, and the non-secure blocking of writes rather than reads.

// File: rtl/errrec_pkg.sv
package errrec_pkg;

    localparam int unsigned REG_W  = 32;
    localparam int unsigned CODE_W = 8;
    localparam int unsigned CE_W   = 2;

    // Bit positions software decodes; fixed by the register layout.
    localparam int unsigned POS_VALID = 30;
    localparam int unsigned POS_OVF   = 27;
    localparam int unsigned POS_CE_LO = 24;

    localparam logic [REG_W-1:0] MASK_VALID = REG_W'(1) << POS_VALID;
    localparam logic [REG_W-1:0] MASK_OVF   = REG_W'(1) << POS_OVF;
    localparam logic [REG_W-1:0] MASK_CE    = REG_W'((1 << CE_W) - 1) << POS_CE_LO;
    localparam logic [REG_W-1:0] MASK_CODE  = REG_W'((1 << CODE_W) - 1);
    localparam logic [REG_W-1:0] MASK_RSV   =
        ~(MASK_VALID | MASK_OVF | MASK_CE | MASK_CODE);

    localparam logic [CE_W-1:0] CE_RECORDED = 2'b10;
    localparam logic [CE_W-1:0] CE_CLEAR    = 2'b11;
    localparam logic [CE_W-1:0] CE_NONE     = 2'b00;

    // Flag state held by the register.
    typedef struct packed {
        logic            valid;
        logic            ovf;
        logic [CE_W-1:0] ce;
    } flags_t;

    // What an accepted write asks for, before guards apply.
    typedef struct packed {
        logic wr;
        logic req_valid_clr;
        logic req_ovf_clr;
        logic req_ce_clr;
    } wr_intent_t;

    function automatic wr_intent_t decode_write(input logic wr,
                                                input logic [REG_W-1:0] data);
        wr_intent_t t;
        t.wr            = wr;
        t.req_valid_clr = wr && ((data & MASK_VALID) != '0);
        t.req_ovf_clr   = wr && ((data & MASK_OVF) != '0);
        t.req_ce_clr    = wr && ((data & MASK_CE) == MASK_CE);
        return t;
    endfunction

    function automatic logic [REG_W-1:0] pack_word(input flags_t f,
                                                  input logic [CODE_W-1:0] code);
        logic [REG_W-1:0] w;
        w = '0;
        w[POS_VALID]                   = f.valid;
        w[POS_OVF]                     = f.ovf;
        w[POS_CE_LO +: CE_W]           = f.ce;
        w[CODE_W-1:0]                  = code;
        return w;
    endfunction

endpackage

// File: rtl/errrec_access.sv
module errrec_access
    import errrec_pkg::*;
(
    input  logic             sel_i,
    input  logic             we_i,
    input  logic             ns_i,
    input  logic             ns_allow_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic             rd_ok_o,
    output wr_intent_t       intent_o
);

    logic granted;

    // A non-secure access is dropped unless explicitly allowed.
    always_comb begin
        granted  = sel_i && (!ns_i || ns_allow_i);
        rd_ok_o  = granted && !we_i;
        intent_o = decode_write(granted && we_i, wdata_i);
    end

endmodule

// File: rtl/errrec_flags.sv
module errrec_flags
    import errrec_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       err_i,
    input  wr_intent_t intent_i,
    output flags_t     flags_o,
    output logic       valid_clr_o
);

    flags_t q;
    logic   ovf_clr, ce_clr, valid_clr;
    logic   ce_busy;

    always_comb begin
        ce_busy   = (q.ce != CE_NONE);
        ovf_clr   = intent_i.req_ovf_clr;
        // Field clear is held off while overflow stays set.
        ce_clr    = intent_i.req_ce_clr && (!q.ovf || ovf_clr);
        // Valid clear is held off while the field stays set.
        valid_clr = intent_i.req_valid_clr && (!ce_busy || ce_clr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            if (err_i) begin
                q.valid <= 1'b1;
                q.ce    <= CE_RECORDED;
                if (ce_busy) q.ovf <= 1'b1;
                else if (ovf_clr) q.ovf <= 1'b0;
            end else begin
                if (valid_clr) q.valid <= 1'b0;
                if (ce_clr)    q.ce    <= CE_NONE;
                if (ovf_clr)   q.ovf   <= 1'b0;
            end
        end
    end

    assign flags_o     = q;
    assign valid_clr_o = valid_clr;

    assert_valid_set_R2: assert property (@(posedge clk) disable iff (rst)
        err_i |=> q.valid);

    assert_ce_set_R4: assert property (@(posedge clk) disable iff (rst)
        err_i |=> q.ce == CE_RECORDED);

    assert_ce_legal_R4: assert property (@(posedge clk) disable iff (rst)
        q.ce == CE_NONE || q.ce == CE_RECORDED);

    assert_no_lost_ovf_R3: assert property (@(posedge clk) disable iff (rst)
        err_i && q.ce != CE_NONE |=> q.ovf);

    assert_ce_guard_R5: assert property (@(posedge clk) disable iff (rst)
        q.ovf && intent_i.req_ce_clr && !intent_i.req_ovf_clr
        |=> q.ce == $past(q.ce));

    assert_valid_guard_R6: assert property (@(posedge clk) disable iff (rst)
        q.ce != CE_NONE && intent_i.req_valid_clr && !intent_i.req_ce_clr
        |=> q.valid);

endmodule

// File: rtl/errrec_code.sv
module errrec_code
    import errrec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              err_i,
    input  logic [CODE_W-1:0] err_code_i,
    input  logic              valid_i,
    input  logic              valid_clr_i,
    output logic [CODE_W-1:0] code_o
);

    logic [CODE_W-1:0] code_q;
    logic              capture, wipe;

    always_comb begin
        capture = err_i && (!valid_i || valid_clr_i);
        wipe    = valid_clr_i && !err_i;
    end

    always_ff @(posedge clk) begin
        if (rst)          code_q <= '0;
        else if (capture) code_q <= err_code_i;
        else if (wipe)    code_q <= '0;
    end

    assign code_o = code_q;

    assert_code_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        valid_i && !valid_clr_i |=> $stable(code_q));

    assert_code_zero_R7: assert property (@(posedge clk) disable iff (rst)
        !valid_i |-> code_q == '0);

endmodule

// File: rtl/errrec_status.sv
module errrec_status
    import errrec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              err_valid_i,
    input  logic [CODE_W-1:0] err_code_i,
    input  logic              ns_allow_i,
    input  logic              reg_sel_i,
    input  logic              reg_we_i,
    input  logic              reg_ns_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o
);

    wr_intent_t        intent;
    flags_t            flags;
    logic              rd_ok;
    logic              valid_clr;
    logic [CODE_W-1:0] code;

    errrec_access u_access (
        .sel_i      (reg_sel_i),
        .we_i       (reg_we_i),
        .ns_i       (reg_ns_i),
        .ns_allow_i (ns_allow_i),
        .wdata_i    (reg_wdata_i),
        .rd_ok_o    (rd_ok),
        .intent_o   (intent)
    );

    errrec_flags u_flags (
        .clk         (clk),
        .rst         (rst),
        .err_i       (err_valid_i),
        .intent_i    (intent),
        .flags_o     (flags),
        .valid_clr_o (valid_clr)
    );

    errrec_code u_code (
        .clk         (clk),
        .rst         (rst),
        .err_i       (err_valid_i),
        .err_code_i  (err_code_i),
        .valid_i     (flags.valid),
        .valid_clr_i (valid_clr),
        .code_o      (code)
    );

    assign reg_rdata_o = rd_ok ? pack_word(flags, code) : '0;

    assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata_o & MASK_RSV) == '0);

    assert_ns_blocked_R8: assert property (@(posedge clk) disable iff (rst)
        reg_sel_i && reg_ns_i && !ns_allow_i |-> reg_rdata_o == '0);

    assert_unselected_R10: assert property (@(posedge clk) disable iff (rst)
        !reg_sel_i |-> reg_rdata_o == '0);

endmodule

// File: tb/test_errrec_status.sv
module test_errrec_status;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        err_valid_i = 1'b0;
    logic [7:0]  err_code_i = '0;
    logic        ns_allow_i = 1'b1;
    logic        reg_sel_i = 1'b0;
    logic        reg_we_i = 1'b0;
    logic        reg_ns_i = 1'b0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    errrec_status i_errrec_status (.*);

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic ns, output logic [31:0] v);
        @(negedge clk);
        reg_sel_i = 1'b1; reg_we_i = 1'b0; reg_ns_i = ns;
        #1 v = reg_rdata_o;
        reg_sel_i = 1'b0;
    endtask

    task automatic wr(input logic ns, input logic [31:0] d);
        @(negedge clk);
        reg_sel_i = 1'b1; reg_we_i = 1'b1; reg_ns_i = ns; reg_wdata_i = d;
        @(negedge clk);
        reg_sel_i = 1'b0; reg_we_i = 1'b0; reg_wdata_i = '0;
    endtask

    task automatic raise(input logic [7:0] c);
        @(negedge clk);
        err_valid_i = 1'b1; err_code_i = c;
        @(negedge clk);
        err_valid_i = 1'b0; err_code_i = '0;
    endtask

    task automatic expect_word(input string req, input logic [31:0] exp);
        logic [31:0] v;
        rd(1'b0, v);
        check(req, v, exp);
    endtask

    task automatic t_reset;
        expect_word("R1 reset value", 32'h0000_0000);
    endtask

    task automatic t_record;
        raise(8'h5A);
        expect_word("R2 R4 R7 first error", 32'h4200_005A);
        raise(8'h33);
        expect_word("R3 R7 second error keeps earliest code", 32'h4A00_005A);
    endtask

    task automatic t_ignored_writes;
        wr(1'b0, 32'hB4FF_FFFF);
        expect_word("R1 R7 reserved and code writes ignored", 32'h4A00_005A);
        wr(1'b0, 32'h0300_0000);
        expect_word("R5 field clear blocked by overflow", 32'h4A00_005A);
        wr(1'b0, 32'h4000_0000);
        expect_word("R6 valid clear blocked by field", 32'h4A00_005A);
        wr(1'b0, 32'h0100_0000);
        expect_word("R3 R4 write of 0b01 and overflow 0 ignored", 32'h4A00_005A);
    endtask

    task automatic t_staged_clear;
        wr(1'b0, 32'h0800_0000);
        expect_word("R3 overflow cleared alone", 32'h4200_005A);
        wr(1'b0, 32'h0300_0000);
        expect_word("R5 field clear once overflow is 0", 32'h4000_005A);
        wr(1'b0, 32'h4000_0000);
        expect_word("R2 R7 valid clear wipes code", 32'h0000_0000);
    endtask

    task automatic t_full_clear;
        raise(8'h01);
        raise(8'h02);
        wr(1'b0, 32'h4B00_0000);
        expect_word("R5 R6 single write clears all", 32'h0000_0000);
    endtask

    task automatic t_security;
        logic [31:0] v;
        raise(8'h11);
        ns_allow_i = 1'b0;
        rd(1'b1, v);
        check("R8 blocked non-secure read", v, 32'h0);
        wr(1'b1, 32'h4B00_0000);
        expect_word("R8 blocked non-secure write", 32'h4200_0011);
        ns_allow_i = 1'b1;
        rd(1'b1, v);
        check("R8 allowed non-secure read", v, 32'h4200_0011);
        wr(1'b1, 32'h4300_0000);
        expect_word("R8 allowed non-secure clear", 32'h0);
    endtask

    task automatic t_race;
        raise(8'h77);
        @(negedge clk);
        err_valid_i = 1'b1; err_code_i = 8'h88;
        reg_sel_i = 1'b1; reg_we_i = 1'b1; reg_ns_i = 1'b0;
        reg_wdata_i = 32'h4300_0000;
        @(negedge clk);
        err_valid_i = 1'b0; reg_sel_i = 1'b0; reg_we_i = 1'b0; reg_wdata_i = '0;
        expect_word("R9 R7 set wins over clear", 32'h4A00_0088);
        wr(1'b0, 32'h4B00_0000);
        expect_word("R9 cleared after race", 32'h0);
    endtask

    task automatic t_select;
        raise(8'h21);
        @(negedge clk);
        reg_sel_i = 1'b0; reg_we_i = 1'b1; reg_wdata_i = 32'h4B00_0000;
        #1 check("R10 unselected read is zero", reg_rdata_o, 32'h0);
        @(negedge clk);
        reg_we_i = 1'b0; reg_wdata_i = '0;
        expect_word("R10 unselected write ignored", 32'h4200_0021);
        wr(1'b0, 32'h4300_0000);
        expect_word("R10 cleanup", 32'h0);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_record();
        t_ignored_writes();
        t_staged_clear();
        t_full_clear();
        t_security();
        t_race();
        t_select();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule